// File: doc/BRIEF.md
# Peripheral Clock Prescaler and Low-Speed Oscillator Gate

This unit sits in the system-clock domain of a small microcontroller. It produces two kinds of clock enables. The first is a peripheral enable strobe. It divides the system clock by 1, 2 or 4, and software picks the ratio with a two-bit select. The second kind serves a low-speed interval oscillator that runs on its own. Its ticks arrive asynchronously. The unit synchronizes them and turns each one into a single-cycle strobe. It then passes that strobe to a watchdog enable and an interval-timer enable, or holds it back, depending on the oscillator's run/stop state and on whether the CPU is in standby.

A configuration input is captured while reset is asserted. It decides, until the next reset, whether software may stop the oscillator. When stopping is allowed, a stop bit halts the oscillator. In that mode, CPU standby also halts the watchdog while the interval timer keeps counting. When stopping is locked out, the stop bit has no effect, and both consumers keep counting in operation and in standby. The unit also reports that the watchdog clock source is forced to the low-speed oscillator.

Every output is an enable in the system-clock domain. None is a gated clock.

Top module: `pclk_lsosc_ctrl`

## Requirements
- R1: Select code 00 makes `pclk_en` high every cycle, 01 every 2nd cycle and 10 every 4th cycle. Number the cycles j = 0, 1, ... from the first cycle after reset release or after a ratio change. The strobe is high exactly when j mod P = P-1, where P is the ratio.
- R2: Select code 11 leaves the active ratio and the divider phase untouched. `div_illegal` goes high one cycle after the code is presented and drops one cycle after a legal code returns.
- R3: When a legal code different from the active ratio is presented, the divider restarts at j = 0 in the next cycle. Presenting the active code again causes no restart.
- R4: After reset is released, `osc_run` is high whatever the configuration input is.
- R5: `cfg_sw_stoppable` is sampled only while `rst_n` is low. Changing it after reset alters neither the stop behaviour nor `wdt_src_forced`.
- R6: When stopping is permitted, a set `sw_stop` drops `osc_run` one cycle later and suppresses all `wdt_en` and `tmr_en` strobes. Clearing it restores `osc_run` and the strobes.
- R7: When stopping is not permitted, `sw_stop` is ignored: `osc_run` stays high and the strobes continue.
- R8: When stopping is permitted, the oscillator is running and `cpu_standby` is high, `wdt_en` gives no strobes while `tmr_en` keeps one strobe per tick.
- R9: When stopping is not permitted, `wdt_en` and `tmr_en` both give one strobe per tick, in operation and in standby.
- R10: `wdt_src_forced` is high exactly when the captured configuration forbids software stopping.
- R11: Each rising edge of the asynchronous `lsosc_tick` yields exactly one single-cycle strobe after the synchronizer. `wdt_en` is never high without `tmr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; the configuration is captured while it is low |
| div_sel | input | 2 | Peripheral divide select (00 /1, 01 /2, 10 /4, 11 illegal) |
| sw_stop | input | 1 | Software stop request for the low-speed oscillator |
| cfg_sw_stoppable | input | 1 | 1 = software may stop the oscillator (captured in reset) |
| cpu_standby | input | 1 | CPU is in standby |
| lsosc_tick | input | 1 | Asynchronous low-speed oscillator clock |
| pclk_en | output | 1 | Peripheral clock enable strobe |
| div_illegal | output | 1 | Illegal select code is being presented |
| wdt_en | output | 1 | Watchdog count enable strobe |
| tmr_en | output | 1 | Interval timer count enable strobe |
| osc_run | output | 1 | Low-speed oscillator is running |
| wdt_src_forced | output | 1 | Watchdog source locked to the low-speed oscillator |

## Verification
The assertions assume two things about the inputs. First, `cfg_sw_stoppable` holds steady through the last cycles of reset. Second, `lsosc_tick` stays at each level for at least two system cycles, so the synchronizer can see every edge. The stimulus keeps to both. It drives the tick as a square wave with four-cycle phases. It changes configuration and mode inputs only while the tick is low and no strobe is in flight. Strobe counts are compared over whole tick bursts, so the two-to-three-cycle synchronizer latency needs no exact modelling.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned MAX_DIV = 4;
  localparam int unsigned CNT_W   = $clog2(MAX_DIV);

  typedef logic [SEL_W-1:0] div_sel_t;

  localparam div_sel_t SEL_ILLEGAL = 2'b11;

  function automatic logic sel_is_legal(input div_sel_t sel);
    return sel != SEL_ILLEGAL;
  endfunction

  // Terminal count of the divider: ratio minus one.
  function automatic logic [CNT_W-1:0] div_last(input div_sel_t sel);
    logic [CNT_W:0] ratio;
    ratio = (CNT_W+1)'(1) << sel;
    return CNT_W'(ratio - 1'b1);
  endfunction
endpackage

// File: rtl/pclk_prescaler.sv
module pclk_prescaler
  import clkctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  div_sel_t div_sel,
  output logic     pclk_en,
  output logic     div_illegal
);
  div_sel_t         act_sel;
  logic [CNT_W-1:0] cnt;
  logic             illegal_q;

  // Named internal events for the assertions
  logic ratio_change;
  logic at_last;

  assign ratio_change = sel_is_legal(div_sel) && (div_sel != act_sel);
  assign at_last      = (cnt == div_last(act_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel   <= '0;
      cnt       <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= !sel_is_legal(div_sel);
      if (ratio_change) begin
        act_sel <= div_sel;
        cnt     <= '0;
      end else if (at_last) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign pclk_en     = at_last;
  assign div_illegal = illegal_q;

  // R2: an illegal code never moves the active ratio
  p_hold_ratio_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel == SEL_ILLEGAL) |=> (act_sel == $past(act_sel)));

  // R3: a new ratio always starts from a fresh phase
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && act_sel != $past(act_sel)) |-> (cnt == '0));

  // R1: divided strobes are never back-to-back
  p_strobe_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pclk_en && act_sel != '0) |=> (!pclk_en || act_sel == '0));
endmodule

// File: rtl/lstick_sync.sv
module lstick_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_async,
  output logic tick_rise
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   prev_q;
  logic                   synced;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= tick_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-2:0], tick_async};
      end
    end
  endgenerate

  assign synced = chain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= synced;
  end

  assign tick_rise = synced && !prev_q;

  // R11: each detected edge is a single-cycle strobe
  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |=> !tick_rise);
endmodule

// File: rtl/lsosc_gate.sv
module lsosc_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_sw_stoppable,
  input  logic sw_stop,
  input  logic cpu_standby,
  input  logic tick_rise,
  output logic wdt_en,
  output logic tmr_en,
  output logic osc_run,
  output logic wdt_src_forced
);
  logic stop_allowed;
  logic run_q;
  logic wdt_hold;

  // Configuration captured on clock edges while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) stop_allowed <= cfg_sw_stoppable;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b1;
    else        run_q <= !(stop_allowed && sw_stop);
  end

  assign wdt_hold       = stop_allowed && cpu_standby;
  assign tmr_en         = tick_rise && run_q;
  assign wdt_en         = tmr_en && !wdt_hold;
  assign osc_run        = run_q;
  assign wdt_src_forced = !stop_allowed;

  // R5: the captured configuration never moves after reset
  p_cfg_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(stop_allowed));

  // R6: a permitted stop request halts the oscillator next cycle
  p_stop_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_allowed && sw_stop) |=> !osc_run);

  // R7: a locked oscillator is always running
  p_stop_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && wdt_src_forced |-> osc_run);

  // R11: the watchdog never counts alone; the timer needs a running oscillator
  p_wdt_implies_tmr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_en |-> tmr_en);
  p_tmr_needs_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_en |-> osc_run);
endmodule

// File: rtl/pclk_lsosc_ctrl.sv
module pclk_lsosc_ctrl
  import clkctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             sw_stop,
  input  logic             cfg_sw_stoppable,
  input  logic             cpu_standby,
  input  logic             lsosc_tick,
  output logic             pclk_en,
  output logic             div_illegal,
  output logic             wdt_en,
  output logic             tmr_en,
  output logic             osc_run,
  output logic             wdt_src_forced
);
  logic tick_rise;

  pclk_prescaler u_presc (
    .clk         (clk),
    .rst_n       (rst_n),
    .div_sel     (div_sel),
    .pclk_en     (pclk_en),
    .div_illegal (div_illegal)
  );

  lstick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_async (lsosc_tick),
    .tick_rise  (tick_rise)
  );

  lsosc_gate u_gate (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_sw_stoppable (cfg_sw_stoppable),
    .sw_stop          (sw_stop),
    .cpu_standby      (cpu_standby),
    .tick_rise        (tick_rise),
    .wdt_en           (wdt_en),
    .tmr_en           (tmr_en),
    .osc_run          (osc_run),
    .wdt_src_forced   (wdt_src_forced)
  );

  // R4: the oscillator runs in the first cycle after reset
  p_run_after_reset_r4: assert property (@(posedge clk)
    (rst_n && !$past(rst_n)) |-> osc_run);
endmodule

// File: tb/pclk_lsosc_ctrl_tb_top.sv
module pclk_lsosc_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] div_sel = 2'b00;
  logic       sw_stop = 1'b0;
  logic       cfg_sw_stoppable = 1'b1;
  logic       cpu_standby = 1'b0;
  logic       lsosc_tick = 1'b0;
  logic       pclk_en, div_illegal, wdt_en, tmr_en, osc_run, wdt_src_forced;

  int n_checks = 0;
  int n_fail   = 0;
  int wdt_cnt  = 0;
  int tmr_cnt  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  pclk_lsosc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .sw_stop(sw_stop),
    .cfg_sw_stoppable(cfg_sw_stoppable), .cpu_standby(cpu_standby),
    .lsosc_tick(lsosc_tick), .pclk_en(pclk_en), .div_illegal(div_illegal),
    .wdt_en(wdt_en), .tmr_en(tmr_en), .osc_run(osc_run),
    .wdt_src_forced(wdt_src_forced)
  );

  always @(negedge clk) begin
    if (rst_n && wdt_en) wdt_cnt++;
    if (rst_n && tmr_en) tmr_cnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit cfg);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_sw_stoppable = cfg;
    sw_stop = 1'b0;
    cpu_standby = 1'b0;
    div_sel = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Burst of k ticks, then count strobes over the burst
  task automatic burst_check(input int k, input int exp_wdt, input int exp_tmr, input string tag);
    wait_cyc(3);
    wdt_cnt = 0;
    tmr_cnt = 0;
    for (int i = 0; i < k; i++) begin
      lsosc_tick = 1'b1; wait_cyc(4);
      lsosc_tick = 1'b0; wait_cyc(4);
    end
    check(wdt_cnt == exp_wdt, {tag, " wdt"}, wdt_cnt, exp_wdt);
    check(tmr_cnt == exp_tmr, {tag, " tmr"}, tmr_cnt, exp_tmr);
  endtask

  // Select a ratio and check the strobe phase for n cycles (R1, R3)
  task automatic ratio_check(input logic [1:0] sel, input int n, input string tag);
    int p;
    p = 1 << sel;
    div_sel = sel;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      check(pclk_en == ((j % p) == p - 1), tag, pclk_en, int'((j % p) == p - 1));
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // ---------- stoppable configuration ----------
    do_reset(1'b1);
    @(negedge clk);
    check(osc_run == 1'b1, "R4 run after reset", osc_run, 1);
    check(wdt_src_forced == 1'b0, "R10 not forced", wdt_src_forced, 0);
    check(div_illegal == 1'b0, "R2 reset illegal flag", div_illegal, 0);
    check(pclk_en == 1'b1, "R1 reset ratio /1", pclk_en, 1);
    check(wdt_en == 1'b0 && tmr_en == 1'b0, "R11 no strobe at reset", wdt_en, 0);

    // R1/R3: every ordering of ratio changes
    ratio_check(2'b01, 8,  "R1 /2");
    ratio_check(2'b10, 12, "R3 /2->/4");
    ratio_check(2'b00, 4,  "R1 /1");
    ratio_check(2'b10, 12, "R3 /1->/4");
    ratio_check(2'b01, 8,  "R3 /4->/2");
    ratio_check(2'b00, 3,  "R3 /2->/1");

    // R2: illegal code keeps /2 and its phase; R3: same code again no restart
    ratio_check(2'b01, 3, "R3 restart before illegal");
    div_sel = 2'b11;
    for (int j = 3; j < 9; j++) begin
      @(negedge clk);
      check(pclk_en == ((j % 2) == 1), "R2 ratio held", pclk_en, int'((j % 2) == 1));
      check(div_illegal == 1'b1, "R2 flag high", div_illegal, 1);
    end
    div_sel = 2'b01;
    for (int j = 9; j < 13; j++) begin
      @(negedge clk);
      check(pclk_en == ((j % 2) == 1), "R3 same code no restart", pclk_en, int'((j % 2) == 1));
      check(div_illegal == 1'b0, "R2 flag cleared", div_illegal, 0);
    end

    // R6/R8/R11 oscillator gating
    burst_check(3, 3, 3, "R11 running");
    sw_stop = 1'b1;
    wait_cyc(1);
    check(osc_run == 1'b0, "R6 stopped", osc_run, 0);
    burst_check(3, 0, 0, "R6 stopped");
    sw_stop = 1'b0;
    wait_cyc(1);
    check(osc_run == 1'b1, "R6 restarted", osc_run, 1);
    burst_check(2, 2, 2, "R6 restarted");
    cpu_standby = 1'b1;
    burst_check(3, 0, 3, "R8 standby");
    cpu_standby = 1'b0;

    // R5: late configuration change has no effect
    cfg_sw_stoppable = 1'b0;
    sw_stop = 1'b1;
    wait_cyc(2);
    check(osc_run == 1'b0, "R5 still stoppable", osc_run, 0);
    check(wdt_src_forced == 1'b0, "R5 forced unchanged", wdt_src_forced, 0);
    sw_stop = 1'b0;

    // ---------- locked configuration ----------
    do_reset(1'b0);
    @(negedge clk);
    check(osc_run == 1'b1, "R4 run after reset locked", osc_run, 1);
    check(wdt_src_forced == 1'b1, "R10 forced", wdt_src_forced, 1);
    sw_stop = 1'b1;
    wait_cyc(2);
    check(osc_run == 1'b1, "R7 stop ignored", osc_run, 1);
    burst_check(3, 3, 3, "R7 stop ignored");
    cpu_standby = 1'b1;
    burst_check(3, 3, 3, "R9 standby locked");
    sw_stop = 1'b0;
    burst_check(2, 2, 2, "R9 standby no stop");
    cpu_standby = 1'b0;
    cfg_sw_stoppable = 1'b1;
    sw_stop = 1'b1;
    wait_cyc(2);
    check(osc_run == 1'b1, "R5 locked stays", osc_run, 1);
    check(wdt_src_forced == 1'b1, "R5 forced stays", wdt_src_forced, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule